// File: doc/BRIEF.md
# Clocked Synchronous Serial Byte Receiver

This block takes in bytes over a two-wire link built from a clock line and a data line. With master mode selected, it drives the clock line itself. The clock comes from a programmable divider of the system clock. With master mode cleared, it samples a clock supplied from outside. Data bits are taken on each rising edge of the transfer clock, most significant bit first, into a shift register. Each finished byte moves into a receive buffer and raises a full flag.

In master mode the clock runs on without a gap from one byte to the next. Software keeps a stream going by reading the buffer each time the full flag rises. If a byte finishes while the buffer is still full, an overrun flag is raised and the unread byte is kept. A stop request that is high when a byte finishes parks the clock high. To receive exactly one byte, software raises master mode with the stop request low, waits until the bit counter leaves zero, and then raises the stop request.

Top module: `sync_byte_rx`

## Requirements
- R1: After reset, full and overrun are 0, the bit counter is 0, the clock output enable is 0 and the clock output is 1.
- R2: When enabled with master high, the clock output enable is 1. A rising master starts the clock, which idles high and then toggles every div_sel+1 system cycles, so a full clock period is 2*(div_sel+1) cycles at 50% duty.
- R3: Data is sampled on each rising edge of the transfer clock and shifted in MSB first. The 3-bit bit counter increments on each sampled bit and wraps to 0 after the eighth.
- R4: On the eighth rising edge, if full is 0, the assembled byte is written to rx_data and full is set. A one-cycle rd pulse clears full.
- R5: In master mode successive bytes follow with no pause, so full rises every 16*(div_sel+1) cycles while the buffer is read in time.
- R6: If the eighth rising edge comes while full is 1, overrun is set, rx_data keeps the earlier byte and the new byte is dropped. Overrun stays set until an ovr_clr pulse.
- R7: In master mode, if stop_req is 1 at the eighth rising edge of a byte, the clock parks high and no further edges are made until master is cleared and set again.
- R8: With master low, the clock output enable is 0 and bits are sampled on rising edges of scl_in, with scl_in and sda_in each passed through a two-stage synchronizer.
- R9: Clearing en resets the bit counter, the shift register and the clock generator, and drives the clock output high with its enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable |
| master | input | 1 | 1: drive the transfer clock, 0: take it from scl_in |
| div_sel | input | 4 | Master clock half period minus one, in system cycles |
| stop_req | input | 1 | Park the master clock after the current byte |
| rd | input | 1 | Buffer read strobe, clears full |
| ovr_clr | input | 1 | Clears the overrun flag |
| scl_in | input | 1 | External transfer clock (slave mode) |
| sda_in | input | 1 | Serial data |
| scl_out | output | 1 | Driven clock level |
| scl_oe | output | 1 | Clock line drive enable |
| rx_data | output | 8 | Receive buffer |
| full | output | 1 | Buffer holds an unread byte |
| overrun | output | 1 | A byte was lost to a full buffer |
| bit_cnt | output | 3 | Bits received in the current byte |

## Verification
Master reception is tried with a single byte that is read at once, with back-to-back bytes read in time, and with a byte left unread while the next one arrives. Together these separate correct buffering, exact clock pacing between bytes, and overrun handling that keeps the old byte. The stop request is raised in the middle of a byte to show that the clock stops only at the byte boundary. Two divider settings are compared by the measured clock period. Slave reception uses bench-driven clock and data, including a byte cut off by disable, to show the synchronized edge path and the reset of the bit counter.

// File: rtl/sync_byte_rx.sv
module sync_byte_rx #(
  parameter int DIV_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              master,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              stop_req,
  input  logic              rd,
  input  logic              ovr_clr,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_out,
  output logic              scl_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              full,
  output logic              overrun,
  output logic [$clog2(DATA_W)-1:0] bit_cnt
);
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int HALF_W = DIV_W + 1;

  logic [1:0] scl_sync, sda_sync;
  logic scl_prev;
  logic armed, run, sclk;
  logic [HALF_W-1:0] hcnt;
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b00;
      scl_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_prev <= scl_sync[1];
    end

  wire [HALF_W-1:0] half_m1 = HALF_W'(div_sel);
  wire tick        = run && (hcnt == half_m1);
  wire master_rise = tick && !sclk;
  wire slave_rise  = en && !master && scl_sync[1] && !scl_prev;
  wire rise        = master_rise || slave_rise;
  wire sample      = master ? sda_in : sda_sync[1];
  wire last        = (bit_cnt == CNT_W'(DATA_W - 1));
  wire park        = master_rise && last && stop_req;
  wire [DATA_W-1:0] next_byte = {shreg[DATA_W-2:0], sample};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0;
      run   <= 1'b0;
      sclk  <= 1'b1;
      hcnt  <= '0;
    end else if (!en || !master) begin
      armed <= 1'b0;
      run   <= 1'b0;
      sclk  <= 1'b1;
      hcnt  <= '0;
    end else begin
      armed <= 1'b1;
      if (!armed)    run <= 1'b1;
      else if (park) run <= 1'b0;
      if (tick) begin
        hcnt <= '0;
        sclk <= ~sclk;
      end else if (run) begin
        hcnt <= hcnt + HALF_W'(1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (!en) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (rise) begin
      shreg   <= next_byte;
      bit_cnt <= bit_cnt + CNT_W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data <= '0;
      full    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (rd)      full    <= 1'b0;
      if (ovr_clr) overrun <= 1'b0;
      if (rise && last) begin
        if (full) overrun <= 1'b1;
        else begin
          rx_data <= next_byte;
          full    <= 1'b1;
        end
      end
    end

  assign scl_out = sclk;
  assign scl_oe  = en && master;

  // R9: clock released high whenever disabled
  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> scl_out);
  // R2: the clock only falls while driven in master mode
  a_r2_fall_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_out) |-> $past(en && master));
  // R3: counter only steps by one or clears
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt != $past(bit_cnt)) |-> (bit_cnt == $past(bit_cnt) + CNT_W'(1) || bit_cnt == '0));
  // R4: buffer fills only at a byte boundary
  a_r4_full_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> (bit_cnt == '0));
  // R6: overrun keeps the older byte
  a_r6_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $stable(rx_data));
endmodule

// File: tb/sync_byte_rx_test.sv
`timescale 1ns/1ps
module sync_byte_rx_test;
  logic clk = 0, rst_n = 0, en = 0, master = 0, stop_req = 0, rd = 0, ovr_clr = 0;
  logic scl_in = 1, sda_in = 0;
  logic [3:0] div_sel = 4'd2;
  logic scl_out, scl_oe, full, overrun;
  logic [7:0] rx_data;
  logic [2:0] bit_cnt;
  int vecs = 0, errs = 0;
  int cyc = 0, falls = 0, rises = 0, nfull = 0, full_t = 0, fall_t = 0, fall_t_prev = 0;
  logic scl_q = 1, full_q = 0;
  logic [31:0] txw = '0;

  always #2.5 clk = ~clk;

  sync_byte_rx uut (.clk, .rst_n, .en, .master, .div_sel, .stop_req, .rd, .ovr_clr,
    .scl_in, .sda_in, .scl_out, .scl_oe, .rx_data, .full, .overrun, .bit_cnt);

  always @(negedge clk) begin
    cyc++;
    if (scl_q && !scl_out) begin
      falls++; fall_t_prev = fall_t; fall_t = cyc;
      if (master) begin sda_in = txw[31]; txw = txw << 1; end
    end
    if (!scl_q && scl_out) rises++;
    scl_q = scl_out;
    if (full && !full_q) begin nfull++; full_t = cyc; end
    full_q = full;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin errs++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd = 1; @(negedge clk) rd = 0;
  endtask

  task automatic wait_full(input int n0);
    while (nfull == n0) @(negedge clk);
  endtask

  task automatic cleanup();
    @(negedge clk) master = 0; en = 0; stop_req = 0; rd = 1; ovr_clr = 1;
    @(negedge clk) rd = 0; ovr_clr = 0; en = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic slave_byte(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      scl_in = 0; sda_in = b[i]; repeat (4) @(negedge clk);
      scl_in = 1; repeat (4) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(full == 0 && overrun == 0, "R1 flags", {full, overrun}, 0);
    chk(bit_cnt == 0, "R1 bit_cnt", bit_cnt, 0);
    chk(scl_oe == 0 && scl_out == 1, "R1 clock", {scl_oe, scl_out}, 1);
  endtask

  task automatic t_master_single();
    int n0 = nfull;
    txw = {8'hA5, 24'h0}; div_sel = 2;
    @(negedge clk) en = 1; master = 1;
    @(negedge clk) chk(scl_oe == 1, "R2 drive enable", scl_oe, 1);
    wait_full(n0);
    chk(rx_data == 8'hA5, "R3 R4 byte MSB first", rx_data, 8'hA5);
    chk(bit_cnt == 0, "R3 counter wrap", bit_cnt, 0);
    chk(fall_t - fall_t_prev == 6, "R2 period div 2", fall_t - fall_t_prev, 6);
    pulse_rd();
    chk(full == 0, "R4 read clears full", full, 0);
    cleanup();
  endtask

  task automatic t_continuous();
    int n0 = nfull, t1;
    txw = {8'h3C, 8'hC3, 16'h0}; div_sel = 2;
    @(negedge clk) master = 1;
    wait_full(n0); t1 = full_t;
    chk(rx_data == 8'h3C, "R5 first byte", rx_data, 8'h3C);
    pulse_rd();
    wait_full(n0 + 1);
    chk(rx_data == 8'hC3, "R5 second byte", rx_data, 8'hC3);
    chk(full_t - t1 == 48, "R5 no pause", full_t - t1, 48);
    cleanup();
  endtask

  task automatic t_overrun();
    int n0 = nfull, guard = 0;
    txw = {8'h11, 8'h22, 16'h0}; div_sel = 2;
    @(negedge clk) master = 1;
    wait_full(n0);
    while (!overrun && guard < 200) begin @(negedge clk); guard++; end
    chk(overrun == 1, "R6 overrun set", overrun, 1);
    chk(rx_data == 8'h11 && full == 1, "R6 old byte kept", rx_data, 8'h11);
    @(negedge clk) master = 0;
    @(negedge clk) ovr_clr = 1; @(negedge clk) ovr_clr = 0;
    chk(overrun == 0, "R6 overrun cleared", overrun, 0);
    cleanup();
  endtask

  task automatic t_stop();
    int n0 = nfull, r0;
    txw = {8'h5A, 24'hFFFFFF}; div_sel = 2; stop_req = 0;
    @(negedge clk) master = 1;
    while (bit_cnt == 0) @(negedge clk);
    stop_req = 1;
    wait_full(n0); r0 = rises;
    repeat (40) @(negedge clk);
    chk(scl_out == 1, "R7 parked high", scl_out, 1);
    chk(rises == r0 && bit_cnt == 0, "R7 no more edges", rises - r0, 0);
    chk(rx_data == 8'h5A, "R7 single byte", rx_data, 8'h5A);
    cleanup();
  endtask

  task automatic t_divider();
    txw = '0; div_sel = 5;
    @(negedge clk) master = 1;
    while (falls < 3 + fall_t * 0 && 0) @(negedge clk);
    begin int f0 = falls; while (falls < f0 + 2) @(negedge clk); end
    chk(fall_t - fall_t_prev == 12, "R2 period div 5", fall_t - fall_t_prev, 12);
    @(negedge clk) en = 0;
    @(negedge clk);
    chk(scl_out == 1 && scl_oe == 0, "R9 clock released", {scl_oe, scl_out}, 1);
    cleanup();
  endtask

  task automatic t_slave();
    int n0 = nfull;
    @(negedge clk) master = 0;
    chk(scl_oe == 0, "R8 not driving", scl_oe, 0);
    slave_byte(8'hC6, 8); repeat (4) @(negedge clk);
    chk(nfull == n0 + 1 && rx_data == 8'hC6, "R8 slave byte", rx_data, 8'hC6);
    pulse_rd();
    slave_byte(8'hFF, 3); repeat (4) @(negedge clk);
    chk(bit_cnt == 3, "R3 partial count", bit_cnt, 3);
    @(negedge clk) en = 0;
    @(negedge clk) chk(bit_cnt == 0, "R9 counter reset", bit_cnt, 0);
    en = 1;
    slave_byte(8'h81, 8); repeat (4) @(negedge clk);
    chk(rx_data == 8'h81, "R9 clean restart", rx_data, 8'h81);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_master_single();
    t_continuous();
    t_overrun();
    t_stop();
    t_divider();
    t_slave();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    vecs++; errs++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule